// File: doc/BRIEF.md
# Migration decision predictor

This block sits beside the memory stage of a core on a tiled chip whose shared cache is split into per-core slices. Each memory access arrives with its instruction address (PC), the ID of the core whose slice holds the data, and the ID of the core running the thread. If the two IDs agree, the access is local. If they differ, the block looks the PC up in a direct-mapped table. A stored PC means the thread should move to the data's core. An absent PC means the access is sent to the remote slice and answered there.

A run-length detector elsewhere trains the table. It sends insert and remove commands that carry a PC. An insert writes the PC into its slot and replaces whatever PC was there before. A remove clears the slot only when the slot holds exactly that PC. A wrong prediction caused by two PCs sharing a slot changes only the choice between moving and remote access. It never changes which data the program sees.

The lookup flow has a valid qualifier and no back-pressure. A request is taken in every cycle that `lkp_valid` is high, and the decision is given combinationally in that same cycle, so there is no ready pin. Training commands are plain control pins, and one command is accepted per clock edge.

Top module: `migpred_top`

## Requirements
- R1: `dec_valid` equals `lkp_valid` in the same cycle. `dec_code` uses 2'b01 local, 2'b10 remote and 2'b11 migrate, and it is 2'b00 whenever `lkp_valid` is low.
- R2: After reset every slot is empty, so every core-miss lookup (`lkp_home` != `self_core`) returns remote.
- R3: When `lkp_home` equals `self_core`, the decision is local, whatever the table holds.
- R4: On a core miss, the decision is migrate if the slot selected by the lookup PC is valid and holds that exact PC. Otherwise the decision is remote.
- R5: The slot index is PC bits [ALIGN_W+IDX_W-1:ALIGN_W], which is bits [8:2] with the defaults. All remaining PC bits, including the alignment bits, are compared, so a different PC that maps to the same slot returns remote.
- R6: `trn_op` 2'b01 (insert) writes `trn_pc` into its slot and overwrites any PC stored there. The new content is seen by lookups from the next cycle on.
- R7: `trn_op` 2'b10 (remove) empties the slot of `trn_pc` only when the slot is valid and holds exactly `trn_pc`. In every other case the table does not change.
- R8: A lookup in the same cycle as an insert or remove sees the table as it was before that command.
- R9: A command changes only the slot its PC indexes. Decisions for PCs in other slots are unchanged.
- R10: `trn_op` 2'b00 and 2'b11 leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; empties every slot |
| lkp_valid | input | 1 | Lookup request present |
| lkp_pc | input | PC_W | PC of the memory instruction |
| lkp_home | input | CORE_W | Core whose slice holds the data |
| self_core | input | CORE_W | Core currently running the thread |
| dec_valid | output | 1 | Decision present (same cycle as request) |
| dec_code | output | 2 | 00 idle, 01 local, 10 remote, 11 migrate |
| trn_op | input | 2 | 00 none, 01 insert, 10 remove, 11 none |
| trn_pc | input | PC_W | PC carried by the training command |

## Verification
A decision depends combinationally on the current request and the table. The bench therefore changes inputs shortly after a falling edge and samples `dec_code` one time unit later, in the same cycle. A training command takes effect at the next rising edge, so its effect is checked at the following falling-edge sample, one cycle after the command. For R8, the bench sets the command and the matching lookup in the same cycle. It checks that cycle for the old decision and the next cycle for the new one.

// File: rtl/migpred_pkg.sv
package migpred_pkg;

  typedef enum logic [1:0] {
    DEC_IDLE    = 2'b00,
    DEC_LOCAL   = 2'b01,
    DEC_REMOTE  = 2'b10,
    DEC_MIGRATE = 2'b11
  } dec_e;

  typedef enum logic [1:0] {
    TRN_NOP = 2'b00,
    TRN_INS = 2'b01,
    TRN_DEL = 2'b10,
    TRN_RSV = 2'b11
  } trn_e;

endpackage

// File: rtl/migpred_split.sv
// Splits a PC into the slot index and the key kept in that slot.
// The key is every PC bit outside the index field, so that comparing
// key plus slot position is a comparison of the whole PC.
module migpred_split #(
  parameter int PC_W    = 64,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 7,
  parameter int KEY_W   = PC_W - IDX_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [KEY_W-1:0] key
);

  assign idx = pc[ALIGN_W+IDX_W-1:ALIGN_W];

  generate
    if (ALIGN_W == 0) begin : g_noalign
      assign key = pc[PC_W-1:IDX_W];
    end else begin : g_align
      assign key = {pc[PC_W-1:ALIGN_W+IDX_W], pc[ALIGN_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/migpred_table.sv
// Direct-mapped key store with one lookup read port and one training port.
module migpred_table #(
  parameter int ENTRIES = 128,
  parameter int KEY_W   = 57,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_hit,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             cmd_ins,
  input  logic             cmd_del
);

  logic [ENTRIES-1:0] vld_q;
  logic [KEY_W-1:0]   key_q [ENTRIES];
  logic               del_hit;

  // The lookup reads the registered contents, so a command in the same
  // cycle is seen only from the next cycle on.
  assign rd_hit  = vld_q[rd_idx] && (key_q[rd_idx] == rd_key);
  assign del_hit = vld_q[wr_idx] && (key_q[wr_idx] == wr_key);

  generate
    for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
      logic sel;
      assign sel = (wr_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q[s] <= 1'b0;
        end else if (sel && cmd_ins) begin
          vld_q[s] <= 1'b1;
        end else if (sel && cmd_del && del_hit) begin
          vld_q[s] <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (sel && cmd_ins) begin
          key_q[s] <= wr_key;
        end
      end
    end
  endgenerate

  // R6
  ins_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ins |=> vld_q[$past(wr_idx)] && (key_q[$past(wr_idx)] == $past(wr_key)));

  // R7
  del_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_del && del_hit) |=> !vld_q[$past(wr_idx)]);

  // R7
  del_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_del && !del_hit) |=> $stable(vld_q));

  // R10
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ins && !cmd_del) |=> $stable(vld_q));

endmodule

// File: rtl/migpred_decide.sv
// Turns the request, the core comparison and the table result into a decision.
module migpred_decide
  import migpred_pkg::*;
#(
  parameter int CORE_W = 6
) (
  input  logic              req_valid,
  input  logic [CORE_W-1:0] home,
  input  logic [CORE_W-1:0] self_core,
  input  logic              tbl_hit,
  output dec_e              dec
);

  always_comb begin
    if (!req_valid) begin
      dec = DEC_IDLE;
    end else if (home == self_core) begin
      dec = DEC_LOCAL;
    end else if (tbl_hit) begin
      dec = DEC_MIGRATE;
    end else begin
      dec = DEC_REMOTE;
    end
  end

endmodule

// File: rtl/migpred_top.sv
module migpred_top
  import migpred_pkg::*;
#(
  parameter int PC_W    = 64,
  parameter int ENTRIES = 128,
  parameter int ALIGN_W = 2,
  parameter int CORE_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [PC_W-1:0]   lkp_pc,
  input  logic [CORE_W-1:0] lkp_home,
  input  logic [CORE_W-1:0] self_core,
  output logic              dec_valid,
  output logic [1:0]        dec_code,
  input  logic [1:0]        trn_op,
  input  logic [PC_W-1:0]   trn_pc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int KEY_W = PC_W - IDX_W;

  logic [IDX_W-1:0] lk_idx, tr_idx;
  logic [KEY_W-1:0] lk_key, tr_key;
  logic             tbl_hit;
  logic             cmd_ins, cmd_del;
  dec_e             dec;

  assign cmd_ins = (trn_op == TRN_INS);
  assign cmd_del = (trn_op == TRN_DEL);

  migpred_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) lk_split_i (
    .pc(lkp_pc), .idx(lk_idx), .key(lk_key)
  );

  migpred_split #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) tr_split_i (
    .pc(trn_pc), .idx(tr_idx), .key(tr_key)
  );

  migpred_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_key(lk_key), .rd_hit(tbl_hit),
    .wr_idx(tr_idx), .wr_key(tr_key),
    .cmd_ins(cmd_ins), .cmd_del(cmd_del)
  );

  migpred_decide #(.CORE_W(CORE_W)) decide_i (
    .req_valid(lkp_valid), .home(lkp_home), .self_core(self_core),
    .tbl_hit(tbl_hit), .dec(dec)
  );

  assign dec_valid = lkp_valid;
  assign dec_code  = dec;

  // R1
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |-> dec_code == DEC_IDLE);

  // R3
  local_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_home == self_core) |-> dec_code == DEC_LOCAL);

  // R4
  ins_then_mig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_op == TRN_INS) |=>
      (!(lkp_valid && lkp_pc == $past(trn_pc) && lkp_home != self_core)
       || dec_code == DEC_MIGRATE));

  // R7
  del_then_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trn_op == TRN_DEL) |=>
      (!(lkp_valid && lkp_pc == $past(trn_pc) && lkp_home != self_core)
       || dec_code == DEC_REMOTE));

endmodule

// File: tb/migpred_top_tb_top.sv
`timescale 1ns/1ps
module migpred_top_tb_top;

  localparam logic [1:0] C_IDLE = 2'b00, C_LOC = 2'b01, C_REM = 2'b10, C_MIG = 2'b11;
  localparam logic [1:0] OP_NOP = 2'b00, OP_INS = 2'b01, OP_DEL = 2'b10, OP_RSV = 2'b11;
  localparam logic [5:0] SELF = 6'd3, FAR = 6'd9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [63:0] lkp_pc = '0;
  logic [5:0]  lkp_home = '0;
  logic [5:0]  self_core = SELF;
  logic        dec_valid;
  logic [1:0]  dec_code;
  logic [1:0]  trn_op = OP_NOP;
  logic [63:0] trn_pc = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  migpred_top dut_i (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .lkp_home(lkp_home), .self_core(self_core), .dec_valid(dec_valid),
    .dec_code(dec_code), .trn_op(trn_op), .trn_pc(trn_pc)
  );

  // Index field is bits [8:2]; A, B, C share slot 0x10.
  localparam logic [63:0] PA = 64'h0000_1000_0000_0040;
  localparam logic [63:0] PB = PA + 64'h200;
  localparam logic [63:0] PC = PA | 64'h1;
  localparam logic [63:0] PD = 64'h0000_2000_0000_0080;
  localparam logic [63:0] PE = 64'h0000_3000_0000_00C0;

  task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Drive one cycle after a falling edge, then wait so combinational output settles.
  task automatic cyc(input logic lv, input logic [63:0] lpc, input logic [5:0] lh,
                     input logic [1:0] op, input logic [63:0] tpc);
    @(negedge clk);
    lkp_valid = lv; lkp_pc = lpc; lkp_home = lh; trn_op = op; trn_pc = tpc;
    #1;
  endtask

  task automatic look(input string req, input logic [63:0] pc, input logic [1:0] exp);
    cyc(1'b1, pc, FAR, OP_NOP, '0);
    chk(req, dec_code, exp);
  endtask

  task automatic t_reset;
    cyc(1'b0, PA, FAR, OP_NOP, '0);
    chk("R1 idle code", dec_code, C_IDLE);
    chk("R1 dec_valid low", {1'b0, dec_valid}, 2'b00);
    look("R2 empty A", PA, C_REM);
    look("R2 empty D", PD, C_REM);
    chk("R1 dec_valid high", {1'b0, dec_valid}, 2'b01);
  endtask

  task automatic t_local_and_hit;
    cyc(1'b0, '0, FAR, OP_INS, PA);
    cyc(1'b1, PA, SELF, OP_NOP, '0);
    chk("R3 local with stored PC", dec_code, C_LOC);
    cyc(1'b1, PD, SELF, OP_NOP, '0);
    chk("R3 local with absent PC", dec_code, C_LOC);
    look("R4 stored PC migrates", PA, C_MIG);
  endtask

  task automatic t_compare;
    look("R5 tag differs same slot", PB, C_REM);
    look("R5 align bits differ same slot", PC, C_REM);
    look("R5 original still hits", PA, C_MIG);
  endtask

  task automatic t_overwrite;
    cyc(1'b0, '0, FAR, OP_INS, PB);
    look("R6 new PC migrates", PB, C_MIG);
    look("R6 evicted PC remote", PA, C_REM);
  endtask

  task automatic t_remove;
    cyc(1'b0, '0, FAR, OP_DEL, PA);
    look("R7 non-matching remove keeps", PB, C_MIG);
    cyc(1'b0, '0, FAR, OP_DEL, PD);
    look("R7 remove on empty slot", PD, C_REM);
    look("R7 other slot after empty remove", PB, C_MIG);
    cyc(1'b0, '0, FAR, OP_DEL, PB);
    look("R7 matching remove clears", PB, C_REM);
  endtask

  task automatic t_same_cycle;
    cyc(1'b1, PD, FAR, OP_INS, PD);
    chk("R8 lookup during insert old", dec_code, C_REM);
    look("R8 after insert new", PD, C_MIG);
    cyc(1'b1, PD, FAR, OP_DEL, PD);
    chk("R8 lookup during remove old", dec_code, C_MIG);
    look("R8 after remove new", PD, C_REM);
  endtask

  task automatic t_reserved;
    cyc(1'b0, '0, FAR, OP_RSV, PE);
    look("R10 reserved op does not insert", PE, C_REM);
    cyc(1'b0, '0, FAR, OP_INS, PE);
    cyc(1'b0, '0, FAR, OP_RSV, PE);
    look("R10 reserved op does not remove", PE, C_MIG);
    cyc(1'b0, '0, FAR, OP_NOP, PE);
    look("R10 nop keeps", PE, C_MIG);
  endtask

  task automatic t_slots;
    logic [63:0] base = 64'h0000_4000_0000_0000;
    for (int i = 0; i < 128; i++) cyc(1'b0, '0, FAR, OP_INS, base + 64'(i << 2));
    for (int i = 0; i < 128; i++) look("R9 every slot held", base + 64'(i << 2), C_MIG);
    cyc(1'b0, '0, FAR, OP_DEL, base + 64'(5 << 2));
    look("R9 removed slot", base + 64'(5 << 2), C_REM);
    look("R9 lower neighbour", base + 64'(4 << 2), C_MIG);
    look("R9 upper neighbour", base + 64'(6 << 2), C_MIG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local_and_hit();
    t_compare();
    t_overwrite();
    t_remove();
    t_same_cycle();
    t_reserved();
    t_slots();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule